// File: doc/BRIEF.md
# UART Receive Status and Request Controller

This block keeps the receive-side status word of a high-speed UART and turns it into one interrupt line and one DMA request line. A receiver core feeds it two data-present levels, one from the head of its receive FIFO and one from a single holding buffer, plus a strobe for each read of the receive data location. It also feeds one-cycle event strobes for a line break, a frame error (a 0 sampled where a stop bit belongs) and a parity mismatch.

Software sees a four-flag status word. The data-present flag follows whichever source the select input picks and drops when the data is read. A mode field routes that flag either to the interrupt or to the DMA request. The three error flags are sticky. Software clears each of them by writing a 1 to its bit, and each one reaches the interrupt through its own enable bit. A build parameter can put a register stage on both request outputs.

Top module: `rxs_status_ctrl`

## Requirements
- R1: While rst_ni is low, every status bit reads 0 and irq_o and dma_req_o are low.
- R2: Status bit 0 takes, at each clock edge, the data-present level of the selected source: the holding buffer when src_hold_i=1, the FIFO head when src_hold_i=0.
- R3: A data_rd_i pulse makes bit 0 read 0 after that edge, even if the selected source is still valid. Bit 0 returns on the next edge if the source is still valid.
- R4: A register write never changes bit 0, and a 0 written to any bit changes nothing.
- R5: break_evt_i, frame_evt_i and parity_evt_i set status bits 1, 2 and 3 on the next edge. Each of those bits then stays set until it is cleared.
- R6: Writing 1 to bit 1, 2 or 3 clears that bit. If an event for the same bit arrives in the same cycle, the bit stays set.
- R7: irq_o is high exactly when either of these holds: (a) some bit k in 1..3 is set and irq_en_i[k]=1; (b) bit 0 is set, irq_en_i[0]=1 and rx_mode_i=2'b01.
- R8: dma_req_o is high exactly when bit 0 is set and rx_mode_i is 2'b10 or 2'b11. It falls as soon as bit 0 clears.
- R9: With rx_mode_i=2'b00, bit 0 still updates but drives neither irq_o nor dma_req_o.
- R10: Status bits DATA_W-1 down to 4 always read 0.
- R11: With OUT_REG=1, irq_o and dma_req_o take one clock edge longer than the R7/R8 functions of the current flags and controls. With OUT_REG=0 they follow those functions directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_vld_i | input | 1 | FIFO head holds received data |
| hold_vld_i | input | 1 | Holding buffer holds received data |
| src_hold_i | input | 1 | 1 selects the holding buffer, 0 selects the FIFO head |
| data_rd_i | input | 1 | Read strobe for the receive data location |
| break_evt_i | input | 1 | Break reached the receive head |
| frame_evt_i | input | 1 | Stop-bit error strobe |
| parity_evt_i | input | 1 | Parity mismatch strobe |
| reg_wr_i | input | 1 | Status register write strobe |
| reg_wdata_i | input | DATA_W | Status register write data |
| rx_mode_i | input | 2 | Request routing: 00 none, 01 interrupt, 1x DMA |
| irq_en_i | input | 4 | Per-flag interrupt enables, bit k for flag k |
| stat_o | output | DATA_W | Status word |
| irq_o | output | 1 | Level interrupt request |
| dma_req_o | output | 1 | Level DMA request |

## Verification
The bench builds the block with DATA_W=16 and OUT_REG=1. This puts the request register stage under test, so the model must carry the one-edge lag of R11 on every cycle. The narrower word also makes the zero-filled upper field of R10 short enough to check as a whole word. Directed phases cover the case where set and clear meet in the same cycle, read strobes against a source that stays valid, and every mode value. A random phase mixes all inputs at once.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int unsigned RXS_NFLAG = 4;
  localparam int unsigned RXS_NERR  = RXS_NFLAG - 1;
  localparam int unsigned RXS_RDV   = 0;

  typedef enum logic [1:0] {
    RXM_OFF  = 2'b00,
    RXM_IRQ  = 2'b01,
    RXM_DMA0 = 2'b10,
    RXM_DMA1 = 2'b11
  } rx_mode_e;
endpackage

// File: rtl/rxs_rdv_track.sv
module rxs_rdv_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fifo_vld_i,
  input  logic hold_vld_i,
  input  logic src_hold_i,
  input  logic data_rd_i,
  output logic rdv_o
);
  logic sel_vld;
  assign sel_vld = src_hold_i ? hold_vld_i : fifo_vld_i;

  // a read masks the flag for one cycle; a still-valid source re-arms it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdv_o <= 1'b0;
    else         rdv_o <= sel_vld & ~data_rd_i;
  end
endmodule

// File: rtl/rxs_err_bank.sv
module rxs_err_bank #(
  parameter int unsigned NERR = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NERR-1:0] evt_i,
  input  logic [NERR-1:0] clr_i,
  output logic [NERR-1:0] flag_o
);
  for (genvar k = 0; k < NERR; k++) begin : g_flag
    // set has priority over write-1-to-clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[k] <= 1'b0;
      else if (evt_i[k]) flag_o[k] <= 1'b1;
      else if (clr_i[k]) flag_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/rxs_req_gen.sv
module rxs_req_gen
  import rxs_pkg::*;
#(
  parameter int unsigned NFLAG   = RXS_NFLAG,
  parameter bit          OUT_REG = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] flags_i,
  input  logic [NFLAG-1:0] irq_en_i,
  input  rx_mode_e         mode_i,
  output logic             irq_o,
  output logic             dma_o
);
  logic irq_c, dma_c, rdv_irq;

  assign rdv_irq = flags_i[RXS_RDV] & irq_en_i[RXS_RDV] & (mode_i == RXM_IRQ);
  assign irq_c   = rdv_irq | (|(flags_i[NFLAG-1:1] & irq_en_i[NFLAG-1:1]));
  assign dma_c   = flags_i[RXS_RDV] & ((mode_i == RXM_DMA0) | (mode_i == RXM_DMA1));

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irq_o <= 1'b0;
        dma_o <= 1'b0;
      end else begin
        irq_o <= irq_c;
        dma_o <= dma_c;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign irq_o = irq_c;
    assign dma_o = dma_c;
  end
endmodule

// File: rtl/rxs_status_ctrl.sv
module rxs_status_ctrl
  import rxs_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter bit          OUT_REG = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_vld_i,
  input  logic              hold_vld_i,
  input  logic              src_hold_i,
  input  logic              data_rd_i,
  input  logic              break_evt_i,
  input  logic              frame_evt_i,
  input  logic              parity_evt_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [1:0]        rx_mode_i,
  input  logic [3:0]        irq_en_i,
  output logic [DATA_W-1:0] stat_o,
  output logic              irq_o,
  output logic              dma_req_o
);
  logic [RXS_NFLAG-1:0] flags;
  logic [RXS_NERR-1:0]  err_evt, err_clr;
  logic                 unused_wdata;

  // bit 0 of the write data is not a clear; upper bits are reserved
  assign unused_wdata = reg_wdata_i[0] ^ (^reg_wdata_i[DATA_W-1:RXS_NFLAG]);

  assign err_evt = {parity_evt_i, frame_evt_i, break_evt_i};
  assign err_clr = {RXS_NERR{reg_wr_i}} & reg_wdata_i[RXS_NFLAG-1:1];

  rxs_rdv_track u_rdv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fifo_vld_i (fifo_vld_i),
    .hold_vld_i (hold_vld_i),
    .src_hold_i (src_hold_i),
    .data_rd_i  (data_rd_i),
    .rdv_o      (flags[RXS_RDV])
  );

  rxs_err_bank #(.NERR(RXS_NERR)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (err_evt),
    .clr_i  (err_clr),
    .flag_o (flags[RXS_NFLAG-1:1])
  );

  rxs_req_gen #(.NFLAG(RXS_NFLAG), .OUT_REG(OUT_REG)) u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flags_i  (flags),
    .irq_en_i (irq_en_i),
    .mode_i   (rx_mode_e'(rx_mode_i)),
    .irq_o    (irq_o),
    .dma_o    (dma_req_o)
  );

  assign stat_o = {{(DATA_W-RXS_NFLAG){1'b0}}, flags};
endmodule

// File: rtl/rxs_status_chk.sv
module rxs_status_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter bit          OUT_REG = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fifo_vld_i,
  input logic              hold_vld_i,
  input logic              src_hold_i,
  input logic              data_rd_i,
  input logic              break_evt_i,
  input logic              frame_evt_i,
  input logic              reg_wr_i,
  input logic [3:0]        wlo_i,
  input logic [1:0]        rx_mode_i,
  input logic [3:0]        irq_en_i,
  input logic [DATA_W-1:0] stat_o,
  input logic              irq_o,
  input logic              dma_req_o
);
  logic       v0, v1;
  logic [1:0] mode_v;
  logic [3:0] en_v, flg_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v0 <= 1'b0;
      v1 <= 1'b0;
    end else begin
      v0 <= 1'b1;
      v1 <= v0;
    end
  end

  if (OUT_REG) begin : g_lag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_v <= '0;
        en_v   <= '0;
        flg_v  <= '0;
      end else begin
        mode_v <= rx_mode_i;
        en_v   <= irq_en_i;
        flg_v  <= stat_o[3:0];
      end
    end
  end else begin : g_now
    assign mode_v = rx_mode_i;
    assign en_v   = irq_en_i;
    assign flg_v  = stat_o[3:0];
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (stat_o == '0 && !irq_o && !dma_req_o);
    end
  end

  p_rdv_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1 && $past(!data_rd_i && (src_hold_i ? hold_vld_i : fifo_vld_i)) |-> stat_o[0]);

  p_rdv_read_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1 && $past(data_rd_i) |-> !stat_o[0]);

  p_bit0_write_ign_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1 && $past(reg_wr_i && wlo_i[0] && !(src_hold_i ? hold_vld_i : fifo_vld_i)) |-> !stat_o[0]);

  p_break_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1 && $past(break_evt_i) |-> stat_o[1]);

  p_frame_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1 && $past(stat_o[2]) && !$past(reg_wr_i && wlo_i[2]) |-> stat_o[2]);

  p_w1c_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1 && $past(reg_wr_i && wlo_i[1] && !break_evt_i) |-> !stat_o[1]);

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1 && $past(reg_wr_i && wlo_i[2] && frame_evt_i) |-> stat_o[2]);

  p_irq_needs_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1 && irq_o |-> (en_v & flg_v) != 4'b0);

  p_dma_needs_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1 && dma_req_o |-> mode_v[1] && flg_v[0]);

  p_mode_off_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1 && mode_v == 2'b00 && (en_v[3:1] & flg_v[3:1]) == 3'b0 |-> !irq_o && !dma_req_o);

  p_upper_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[DATA_W-1:4] == '0);
endmodule

bind rxs_status_ctrl rxs_status_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fifo_vld_i  (fifo_vld_i),
  .hold_vld_i  (hold_vld_i),
  .src_hold_i  (src_hold_i),
  .data_rd_i   (data_rd_i),
  .break_evt_i (break_evt_i),
  .frame_evt_i (frame_evt_i),
  .reg_wr_i    (reg_wr_i),
  .wlo_i       (reg_wdata_i[3:0]),
  .rx_mode_i   (rx_mode_i),
  .irq_en_i    (irq_en_i),
  .stat_o      (stat_o),
  .irq_o       (irq_o),
  .dma_req_o   (dma_req_o)
);

// File: tb/tb_rxs_status_ctrl.sv
module tb_rxs_status_ctrl;
  localparam int unsigned DW = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic fifo_vld_i = 0, hold_vld_i = 0, src_hold_i = 0, data_rd_i = 0;
  logic break_evt_i = 0, frame_evt_i = 0, parity_evt_i = 0, reg_wr_i = 0;
  logic [DW-1:0] reg_wdata_i = '0;
  logic [1:0] rx_mode_i = 2'b00;
  logic [3:0] irq_en_i = 4'b0;
  logic [DW-1:0] stat_o;
  logic irq_o, dma_req_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  string tag = "R1";

  logic [3:0] m_flags = 4'b0;
  logic m_irq = 0, m_dma = 0;

  always #10 clk_i = ~clk_i;

  rxs_status_ctrl #(.DATA_W(DW), .OUT_REG(1'b1)) dut (.*);

  // reference model: requests lag the flag/controls by one edge (R11)
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_flags = 4'b0; m_irq = 0; m_dma = 0;
    end else begin
      m_irq = (|(m_flags[3:1] & irq_en_i[3:1])) ||
              (m_flags[0] && irq_en_i[0] && rx_mode_i == 2'b01);
      m_dma = m_flags[0] && rx_mode_i[1];
      for (int k = 1; k < 4; k++)
        m_flags[k] = (k == 1 ? break_evt_i : k == 2 ? frame_evt_i : parity_evt_i) ||
                     (m_flags[k] && !(reg_wr_i && reg_wdata_i[k]));
      m_flags[0] = (src_hold_i ? hold_vld_i : fifo_vld_i) && !data_rd_i;
    end
  end

  always @(negedge clk_i) begin
    if (!done) begin
      n_vec++;
      if (stat_o !== {{(DW-4){1'b0}}, m_flags} || irq_o !== m_irq || dma_req_o !== m_dma) begin
        n_bad++;
        $display("FAIL %s t=%0t stat=%h/%h irq=%b/%b dma=%b/%b (actual/expected)",
                 tag, $time, stat_o, {{(DW-4){1'b0}}, m_flags}, irq_o, m_irq, dma_req_o, m_dma);
      end
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); #1;
    end
  endtask

  task automatic quiet();
    data_rd_i = 0; break_evt_i = 0; frame_evt_i = 0; parity_evt_i = 0;
    reg_wr_i = 0; reg_wdata_i = '0;
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    fifo_vld_i = 1; hold_vld_i = 1; break_evt_i = 1; rx_mode_i = 2'b11; irq_en_i = 4'hF;
    step(3);                                   // R1: held in reset despite active inputs
    quiet(); fifo_vld_i = 0; hold_vld_i = 0; rx_mode_i = 2'b00; irq_en_i = 0;
    rst_ni = 1'b1;
    step(2);

    tag = "R2";                                // source select
    fifo_vld_i = 1; step(2);
    hold_vld_i = 1; fifo_vld_i = 0; step(2);
    src_hold_i = 1; step(2);
    hold_vld_i = 0; fifo_vld_i = 1; step(2);

    tag = "R3";                                // read against still-valid source
    hold_vld_i = 1; step(2);
    data_rd_i = 1; step(1); data_rd_i = 0; step(2);
    data_rd_i = 1; step(3); data_rd_i = 0; step(1);

    tag = "R4";                                // writes to bit 0 and zero writes
    hold_vld_i = 0; reg_wr_i = 1; reg_wdata_i = 16'h0001; step(2);
    hold_vld_i = 1; reg_wdata_i = 16'h0001; step(2);
    reg_wr_i = 0; break_evt_i = 1; frame_evt_i = 1; parity_evt_i = 1; step(1);
    quiet(); reg_wr_i = 1; reg_wdata_i = 16'hFFF0; step(2); quiet(); step(1);

    tag = "R5";                                // events set, stay set
    break_evt_i = 1; step(1); quiet(); step(3);
    reg_wr_i = 1; reg_wdata_i = 16'h000E; step(1); quiet(); step(1);
    frame_evt_i = 1; step(1); quiet(); parity_evt_i = 1; step(1); quiet(); step(3);

    tag = "R6";                                // w1c and set-wins
    reg_wr_i = 1; reg_wdata_i = 16'h0004; step(1); quiet(); step(1);
    reg_wr_i = 1; reg_wdata_i = 16'h000A; parity_evt_i = 1; step(1); quiet(); step(2);
    reg_wr_i = 1; reg_wdata_i = 16'h000E; step(1); quiet(); step(2);

    tag = "R7";                                // interrupt routing
    src_hold_i = 0; fifo_vld_i = 1; irq_en_i = 4'h1; rx_mode_i = 2'b01; step(3);
    rx_mode_i = 2'b10; step(2); rx_mode_i = 2'b01; irq_en_i = 4'h0; step(2);
    frame_evt_i = 1; step(1); quiet(); irq_en_i = 4'h4; step(3);
    irq_en_i = 4'h2; step(2); reg_wr_i = 1; reg_wdata_i = 16'h0004; step(1); quiet(); step(2);

    tag = "R8";                                // DMA routing and fall on clear
    rx_mode_i = 2'b10; irq_en_i = 4'hF; step(3);
    rx_mode_i = 2'b11; step(2); data_rd_i = 1; step(1); data_rd_i = 0; step(2);
    fifo_vld_i = 0; step(3);

    tag = "R9";                                // mode off, flag still updates
    rx_mode_i = 2'b00; irq_en_i = 4'h1; fifo_vld_i = 1; step(3);
    fifo_vld_i = 0; step(2); fifo_vld_i = 1; step(2);

    tag = "R10";
    reg_wr_i = 1; reg_wdata_i = 16'hFFFF; break_evt_i = 1; step(2); quiet(); step(1);

    tag = "R11";                               // random mix, one-edge request lag
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      fifo_vld_i   = r[0];  hold_vld_i = r[1]; src_hold_i = r[2] & r[3];
      data_rd_i    = r[4] & r[5];
      break_evt_i  = (r[8:6] == 0); frame_evt_i = (r[11:9] == 0); parity_evt_i = (r[14:12] == 0);
      reg_wr_i     = (r[16:15] == 0); reg_wdata_i = r[31:16];
      if (r[20:17] == 0) rx_mode_i = r[22:21];
      if (r[26:23] == 0) irq_en_i = r[30:27];
      step(1);
    end
    quiet();
    rst_ni = 1'b0; tag = "R1"; step(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule